// File: doc/BRIEF.md
# Machine Interrupt Enable and Selection

This block keeps the machine-level interrupt-enable and interrupt-pending registers of a core that runs only in machine mode. Software reaches both registers through a simple register port. A write changes only the bits that a fixed write mask allows. A read returns the stored value gated by the delegation word. The machine timer-pending bit is not software-controlled. It copies a synchronous timer-request input on every clock.

On every cycle the block forms its candidate set. A bit is a candidate when it is pending, enabled and not delegated, and only while interrupts are globally enabled. From that set it picks the candidate with the lowest bit number. It then gives the trap controller a registered one-cycle take request together with the selected cause index. Changes to the status enable, the enable register or the pending register are all seen at the next evaluation. No explicit refresh is needed.

Top module: `mirq_ctrl`

## Requirements
- R1: A write with `csr_wsel_i`=0 (enable register) updates only the bits set in 0xBBB. Every other bit keeps its previous value, and bits outside 0xBBB read as 0.
- R2: A write with `csr_wsel_i`=1 (pending register) updates only the bits set in 0xB3B. This is 0xBBB without bit 7, so the write leaves bit 7 untouched.
- R3: `csr_rdata_o` equals the register chosen by `csr_rsel_i` (0 = enable, 1 = pending) ANDed bit by bit with `deleg_i`, zero-extended. It follows the register contents and the inputs in the same cycle.
- R4: Bit 7 of the pending register takes the value of `timer_irq_i` at each rising clock edge, whatever the software writes.
- R5: Interrupts are globally enabled when `priv_i` is not 3 (machine), or when `priv_i` is 3 and `mstatus_mie_i` is 1. While they are disabled, no take request is produced.
- R6: The candidate set is pending AND enable AND NOT `deleg_i[11:0]`. `take_o` rises one clock after a cycle with a non-empty candidate set, and stays low after a cycle with an empty set.
- R7: `cause_o` is registered each clock with the lowest-numbered bit of the candidate set of the previous cycle, or 0 when that set is empty.
- R8: `take_o` is never high on two consecutive cycles. It is low in the cycle after any cycle in which `trap_busy_i` is 1.
- R9: During and right after reset, both registers are 0, `take_o` is 0 and `cause_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_we_i | input | 1 | Register write strobe |
| csr_wsel_i | input | 1 | Write target: 0 enable, 1 pending |
| csr_wdata_i | input | 32 | Write data |
| csr_rsel_i | input | 1 | Read source: 0 enable, 1 pending |
| csr_rdata_o | output | 32 | Read data, gated by delegation |
| deleg_i | input | 32 | Delegation word |
| priv_i | input | 2 | Current privilege level, 3 = machine |
| mstatus_mie_i | input | 1 | Machine global interrupt enable from status |
| timer_irq_i | input | 1 | Synchronous timer interrupt request |
| trap_busy_i | input | 1 | Trap controller is busy with a trap |
| take_o | output | 1 | Registered one-cycle take request |
| cause_o | output | 4 | Selected interrupt cause index |

## Verification
Register writes and the timer sample land at the rising edge that follows the stimulus. The read port is combinational from the registers, so a written value can be read a quarter period after that edge. The take request and the cause pass through one more register, so they appear one edge after the cycle in which the candidate set is formed. That is one edge after a write, or after a change of privilege, status enable, delegation or busy. A behavioural model steps at each rising edge from the inputs held stable since the falling edge, and every output is compared 5 ns after the edge. Pulse counts are taken over six consecutive samples, so the alternating take pattern gives the same count whatever its phase.

// File: rtl/mirq_pkg.sv
// Package: shared constants and types for the machine interrupt block.
// Assumes a two-bit privilege encoding in which 3 is the machine level.
package mirq_pkg;

    typedef enum logic [1:0] {
        PRIV_USER    = 2'd0,
        PRIV_SUPER   = 2'd1,
        PRIV_RSVD    = 2'd2,
        PRIV_MACHINE = 2'd3
    } priv_e;

    typedef enum logic {
        REG_ENABLE  = 1'b0,
        REG_PENDING = 1'b1
    } reg_sel_e;

    // Fixed write mask of the enable register
    localparam logic [11:0] ENABLE_WMASK = 12'hBBB;
    // Pending bit driven by the timer request
    localparam int TIMER_BIT = 7;

endpackage

// File: rtl/mirq_mask_reg.sv
// Module: a register in which each bit is either software-writable, held
// at zero, or a copy of a hardware input, as selected by parameters.
// Assumes single-cycle write strobes and a synchronous active-low reset.
module mirq_mask_reg #(
    parameter int              W         = 12,
    parameter logic [W-1:0]    WMASK     = '0,
    parameter int              HW_BIT    = 7,
    parameter int              HW_MIRROR = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    input  logic         hw_in,
    output logic [W-1:0] q
);

    // Inputs that some bit configurations do not consume
    logic unused_inputs;
    assign unused_inputs = ^{we, wdata, hw_in};

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic bit_q;
        if ((HW_MIRROR != 0) && (i == HW_BIT)) begin : g_hw
            // Copy the hardware request each cycle
            always_ff @(posedge clk) begin
                if (!rst_n) bit_q <= 1'b0;
                else        bit_q <= hw_in;
            end
        end else if (WMASK[i]) begin : g_sw
            // Software-writable bit, loaded on a write strobe
            always_ff @(posedge clk) begin
                if (!rst_n)  bit_q <= 1'b0;
                else if (we) bit_q <= wdata[i];
            end
        end else begin : g_zero
            // Bit not implemented, tied low
            assign bit_q = 1'b0;
        end
        assign q[i] = bit_q;
    end

endmodule

// File: rtl/mirq_select.sv
// Module: forms the candidate set from pending, enable, delegation and the
// global enable, and finds its lowest-numbered member.
// Assumes W fits in CW bits of index; purely combinational.
module mirq_select #(
    parameter int W  = 12,
    parameter int CW = $clog2(W)
) (
    input  logic [W-1:0]  pend,
    input  logic [W-1:0]  en,
    input  logic [W-1:0]  deleg,
    input  logic          glb_en,
    output logic [W-1:0]  cand,
    output logic          any,
    output logic [CW-1:0] idx
);

    // Candidate bits: pending, enabled, not delegated, globally allowed
    always_comb begin
        cand = glb_en ? (pend & en & ~deleg) : '0;
    end

    // Lowest index wins: scan downward so the last hit is the smallest
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (cand[i]) idx = CW'(i);
        end
    end

    // Non-empty flag for the take logic
    assign any = |cand;

endmodule

// File: rtl/mirq_take_reg.sv
// Module: registers the take request and cause toward the trap controller.
// Assumes the controller raises busy while handling a trap; the request
// drops after every pulse so it never holds high two cycles running.
module mirq_take_reg #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          any,
    input  logic [CW-1:0] idx,
    input  logic          busy,
    output logic          take,
    output logic [CW-1:0] cause
);

    // Pulse generation and cause capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take  <= 1'b0;
            cause <= '0;
        end else begin
            take  <= any & ~busy & ~take;
            cause <= idx;
        end
    end

endmodule

// File: rtl/mirq_ctrl.sv
// Module: top of the machine interrupt enable and selection block. Holds
// the enable and pending registers, gates reads by delegation, and issues
// a take request with the lowest candidate cause.
// Assumes XLEN >= IRQ_W and that all inputs are synchronous to clk.
module mirq_ctrl
    import mirq_pkg::*;
#(
    parameter int          XLEN    = 32,
    parameter int          IRQ_W   = 12,
    parameter logic [IRQ_W-1:0] EN_MASK = IRQ_W'(ENABLE_WMASK),
    parameter int          TMR_BIT = TIMER_BIT,
    localparam int         CAUSE_W = $clog2(IRQ_W),
    localparam logic [IRQ_W-1:0] PEND_MASK = EN_MASK & ~(IRQ_W'(1) << TMR_BIT)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               csr_we_i,
    input  logic               csr_wsel_i,
    input  logic [XLEN-1:0]    csr_wdata_i,
    input  logic               csr_rsel_i,
    output logic [XLEN-1:0]    csr_rdata_o,
    input  logic [XLEN-1:0]    deleg_i,
    input  logic [1:0]         priv_i,
    input  logic               mstatus_mie_i,
    input  logic               timer_irq_i,
    input  logic               trap_busy_i,
    output logic               take_o,
    output logic [CAUSE_W-1:0] cause_o
);

    logic [IRQ_W-1:0]   en_q;
    logic [IRQ_W-1:0]   pend_q;
    logic [IRQ_W-1:0]   deleg_lo;
    logic [IRQ_W-1:0]   cand;
    logic               cand_any;
    logic [CAUSE_W-1:0] cand_idx;
    logic               glb_en;
    logic               we_en;
    logic               we_pend;
    logic [IRQ_W-1:0]   rd_raw;

    // Upper data bits carry no implemented interrupts
    logic unused_hi;
    assign unused_hi = ^{csr_wdata_i[XLEN-1:IRQ_W], deleg_i[XLEN-1:IRQ_W]};

    assign deleg_lo = deleg_i[IRQ_W-1:0];

    // Decode write strobes per target register
    always_comb begin
        we_en   = csr_we_i && (csr_wsel_i == REG_ENABLE);
        we_pend = csr_we_i && (csr_wsel_i == REG_PENDING);
    end

    // Global enable: below machine level, or machine with status enable
    always_comb begin
        glb_en = (priv_i != PRIV_MACHINE) || mstatus_mie_i;
    end

    mirq_mask_reg #(
        .W(IRQ_W), .WMASK(EN_MASK), .HW_BIT(TMR_BIT), .HW_MIRROR(0)
    ) u_enable (
        .clk(clk), .rst_n(rst_n), .we(we_en),
        .wdata(csr_wdata_i[IRQ_W-1:0]), .hw_in(1'b0), .q(en_q)
    );

    mirq_mask_reg #(
        .W(IRQ_W), .WMASK(PEND_MASK), .HW_BIT(TMR_BIT), .HW_MIRROR(1)
    ) u_pending (
        .clk(clk), .rst_n(rst_n), .we(we_pend),
        .wdata(csr_wdata_i[IRQ_W-1:0]), .hw_in(timer_irq_i), .q(pend_q)
    );

    mirq_select #(.W(IRQ_W), .CW(CAUSE_W)) u_select (
        .pend(pend_q), .en(en_q), .deleg(deleg_lo), .glb_en(glb_en),
        .cand(cand), .any(cand_any), .idx(cand_idx)
    );

    mirq_take_reg #(.CW(CAUSE_W)) u_take (
        .clk(clk), .rst_n(rst_n), .any(cand_any), .idx(cand_idx),
        .busy(trap_busy_i), .take(take_o), .cause(cause_o)
    );

    // Read path: chosen register gated by delegation
    always_comb begin
        rd_raw      = (csr_rsel_i == REG_PENDING) ? pend_q : en_q;
        csr_rdata_o = XLEN'(rd_raw & deleg_lo);
    end

endmodule

// File: rtl/mirq_ctrl_chk.sv
// Checker: temporal properties of the machine interrupt block, bound to
// its top. Assumes the synchronous active-low reset of the design.
module mirq_ctrl_chk #(
    parameter int IRQ_W   = 12,
    parameter int TMR_BIT = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             take_o,
    input logic             trap_busy_i,
    input logic             timer_irq_i,
    input logic [1:0]       priv_i,
    input logic             mstatus_mie_i,
    input logic             cand_any,
    input logic [IRQ_W-1:0] pend_q
);

    // R8
    take_no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o);

    // R8
    busy_blocks_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_busy_i |=> !take_o);

    // R5
    glb_off_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((priv_i == 2'd3) && !mstatus_mie_i) |=> !take_o);

    // R6
    take_needs_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cand_any |=> !take_o);

    // R4
    timer_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pend_q[TMR_BIT] == $past(timer_irq_i)));

endmodule

bind mirq_ctrl mirq_ctrl_chk #(.IRQ_W(IRQ_W), .TMR_BIT(TMR_BIT)) u_chk (
    .clk(clk), .rst_n(rst_n), .take_o(take_o), .trap_busy_i(trap_busy_i),
    .timer_irq_i(timer_irq_i), .priv_i(priv_i), .mstatus_mie_i(mstatus_mie_i),
    .cand_any(cand_any), .pend_q(pend_q)
);

// File: tb/tb_mirq_ctrl.sv
// Bench: behavioural reference model stepped on each rising edge and
// compared with the design a quarter period later, plus directed checks.
module tb_mirq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        csr_we_i, csr_wsel_i, csr_rsel_i;
    logic [31:0] csr_wdata_i, csr_rdata_o, deleg_i;
    logic [1:0]  priv_i;
    logic        mstatus_mie_i, timer_irq_i, trap_busy_i;
    logic        take_o;
    logic [3:0]  cause_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // Reference model state
    int m_en, m_pd, m_tk, m_cs;

    always #10 clk = ~clk;

    mirq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .csr_we_i(csr_we_i), .csr_wsel_i(csr_wsel_i),
        .csr_wdata_i(csr_wdata_i), .csr_rsel_i(csr_rsel_i),
        .csr_rdata_o(csr_rdata_o), .deleg_i(deleg_i), .priv_i(priv_i),
        .mstatus_mie_i(mstatus_mie_i), .timer_irq_i(timer_irq_i),
        .trap_busy_i(trap_busy_i), .take_o(take_o), .cause_o(cause_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int lowest(input int v);
        for (int i = 11; i >= 0; i--) if (v[i]) lowest = i;
        if (v == 0) lowest = 0;
    endfunction

    // Model step at each rising edge
    always @(posedge clk) begin
        int cand;
        if (!rst_n) begin
            m_en = 0; m_pd = 0; m_tk = 0; m_cs = 0;
        end else begin
            cand = m_pd & m_en & ~int'(deleg_i[11:0]);
            if (priv_i == 2'd3 && !mstatus_mie_i) cand = 0;
            m_cs = lowest(cand);
            m_tk = (cand != 0 && !trap_busy_i && m_tk == 0) ? 1 : 0;
            if (csr_we_i && !csr_wsel_i) m_en = (m_en & ~'hBBB) | (int'(csr_wdata_i) & 'hBBB);
            if (csr_we_i &&  csr_wsel_i) m_pd = (m_pd & ~'hB3B) | (int'(csr_wdata_i) & 'hB3B);
            m_pd[7] = timer_irq_i;
        end
    end

    // Per-cycle comparison a quarter period after the edge
    always begin
        @(posedge clk);
        #5;
        if (rst_n && !done) begin
            check("R6 take", int'(take_o), m_tk);
            check("R7 cause", int'(cause_o), m_cs);
            check("R3 rdata", int'(csr_rdata_o),
                  (csr_rsel_i ? m_pd : m_en) & int'(deleg_i[11:0]));
        end
    end

    task automatic wr(input bit sel, input int data);
        @(negedge clk);
        csr_we_i = 1'b1; csr_wsel_i = sel; csr_wdata_i = data;
        @(negedge clk);
        csr_we_i = 1'b0;
    endtask

    task automatic sample();
        @(posedge clk);
        #5;
    endtask

    task automatic count_takes(output int n);
        n = 0;
        for (int k = 0; k < 6; k++) begin
            sample();
            n += int'(take_o);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog
    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int n;
        rst_n = 1'b0; csr_we_i = 0; csr_wsel_i = 0; csr_wdata_i = 0; csr_rsel_i = 0;
        deleg_i = 32'hFFF; priv_i = 2'd3; mstatus_mie_i = 0; timer_irq_i = 0; trap_busy_i = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        sample();
        // R9 reset state
        check("R9 take", int'(take_o), 0);
        check("R9 cause", int'(cause_o), 0);
        check("R9 rdata", int'(csr_rdata_o), 0);

        // R1 enable mask
        wr(1'b0, 'hFFFF_FFFF);
        csr_rsel_i = 0;
        sample();
        check("R1 enable mask", int'(csr_rdata_o), 'hBBB);
        // R2 pending mask, timer low
        wr(1'b1, 'hFFF);
        @(negedge clk); csr_rsel_i = 1;
        sample();
        check("R2 pending mask", int'(csr_rdata_o), 'hB3B);
        // R3 delegation gates reads
        @(negedge clk); deleg_i = 0;
        sample();
        check("R3 read gated", int'(csr_rdata_o), 0);

        // R4 timer mirror
        @(negedge clk); deleg_i = 'h080; timer_irq_i = 1;
        sample();
        check("R4 timer set", int'(csr_rdata_o), 'h080);
        wr(1'b1, 0);
        sample();
        check("R4 write ignored", int'(csr_rdata_o), 'h080);
        @(negedge clk); timer_irq_i = 0;
        sample();
        check("R4 timer clear", int'(csr_rdata_o), 0);

        // Candidates: all enabled and pending, nothing delegated
        wr(1'b1, 'hFFF);
        @(negedge clk); deleg_i = 0;
        count_takes(n);
        check("R5 machine mie=0 no take", n, 0);
        @(negedge clk); mstatus_mie_i = 1;
        count_takes(n);
        check("R8 alternating pulses", n, 3);
        check("R7 lowest cause", int'(cause_o), 0);
        @(negedge clk); trap_busy_i = 1;
        count_takes(n);
        check("R8 busy suppresses", n, 0);
        @(negedge clk); trap_busy_i = 0; mstatus_mie_i = 0; priv_i = 2'd0;
        count_takes(n);
        check("R5 lower privilege enables", n, 3);

        // R6 delegation removes candidates
        @(negedge clk); deleg_i = 'h003;
        sample(); sample();
        check("R6 delegated skipped", int'(cause_o), 3);
        wr(1'b1, 'h800);
        sample();
        check("R7 single high cause", int'(cause_o), 11);
        wr(1'b0, 0);
        count_takes(n);
        check("R6 empty set no take", n, 0);
        check("R7 empty cause", int'(cause_o), 0);

        repeat (3) sample();
        finish_run();
    end

endmodule